// File: doc/BRIEF.md
# Virtual End-of-Interrupt Priority Drop Unit

This block carries out one end-of-interrupt write for a virtualised interrupt interface, for either group 0 or group 1. The surrounding interface holds the list entries and the two groups' active-priority vectors. It presents their current values to this block and takes back the updated copies. Each entry has an interrupt ID, a priority, a group bit and a two-bit state. When a write strobe arrives, the block first drops the running priority. To do this it clears the lowest set bit across the two groups' active-priority words. It then looks for an active list entry that holds the written ID. If it finds one, it deactivates that entry. If it finds none, it counts an unmatched end-of-interrupt.

The priority drop comes before any checking of the list entries. The index of the bit that was cleared is turned back into a priority value. That value is compared with the entry's group priority, which is the entry's priority with its subpriority bits removed. The outcome of each write falls into one of five named classes, chosen by a `unique case`:
- `EOI_IGNORE`: the ID is out of range.
- `EOI_NOACT`: no active-priority bit was set.
- `EOI_UNMATCHED`: no active entry holds the ID.
- `EOI_DEACT`: the entry is deactivated.
- `EOI_DROP_ONLY`: split mode is set, or the group or priority does not match.

The outcome is taken on the strobe and takes effect on the next clock edge. Between writes, all outputs hold their values.

Top module: `veoi_drop_unit`

## Requirements
- R1: The interrupt ID is `eoi_data[23:0]`, and the upper bits are not used. If the ID is greater than or equal to `num_irq`, the write changes nothing: the outputs become copies of the current inputs and the counter keeps its value.
- R2: The number of 32-bit active-priority words scanned is `1 << (prebits - 5)`, for `prebits` from 5 to 7. Words are scanned from index 0 upward. A word that is zero in both groups is skipped. Bits in words beyond this count are never cleared.
- R3: In the first word that is non-empty, each group's trailing-zero count is compared, with an empty word counting as 32. The lowest set bit of group 0 is cleared if its count is less than or equal to group 1's count. Otherwise the lowest set bit of group 1 is cleared. Only one bit is cleared per write.
- R4: If no bit is set in any scanned word, the list entries, the vectors and the counter are all left unchanged.
- R5: If no list entry with its active bit set (state bit 1) holds the ID, `eoi_count` goes up by one. It is five bits wide and wraps modulo 32.
- R6: An entry is deactivated when all of the following hold: it is the matching entry, its group bit equals `eoi_grp`, its masked priority equals the dropped priority, and `split_mode` is 0. Deactivation clears state bit 1 and leaves the pending bit (state bit 0) unchanged.
- R7: With `split_mode` set, only the priority drop takes place. The entry stays active and the counter does not change.
- R8: The dropped priority is `(bit + 32*word) << (min_bpr + 1)`. The group-priority mask is `8'hFF << (bpr + 1)`. Here `bpr` is `bpr_g0` for group 0. For group 1 it is `bpr_g1`, or `bpr_g0` when `common_bpr` is set.
- R9: A matching entry whose group or masked priority differs is not deactivated, and the counter is not incremented. The priority drop still takes place.
- R10: When several active entries hold the ID, only the one with the lowest index is considered.
- R11: Each write takes effect at the first rising clock edge at which the strobe is high. Without a strobe, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Write data; the low 24 bits are the ID |
| eoi_grp | input | 1 | Group of the write register (0 or 1) |
| split_mode | input | 1 | Priority drop and deactivation are split |
| num_irq | input | 24 | Number of supported interrupt IDs |
| prebits | input | 3 | Priority bits implemented (5..7) |
| min_bpr | input | 3 | Minimum binary point |
| bpr_g0 | input | 3 | Binary point for group 0 |
| bpr_g1 | input | 3 | Binary point for group 1 |
| common_bpr | input | 1 | Group 1 uses the group-0 binary point |
| lr_id_in | input | NUM_LR*24 | Interrupt ID held in each list entry |
| lr_prio_in | input | NUM_LR*8 | Priority of each list entry |
| lr_grp_in | input | NUM_LR | Group bit of each list entry |
| lr_state_in | input | NUM_LR*2 | Current state of each entry (bit1 active, bit0 pending) |
| apr0_in | input | APR_WORDS*32 | Current group-0 active-priority words |
| apr1_in | input | APR_WORDS*32 | Current group-1 active-priority words |
| lr_state_out | output | NUM_LR*2 | Updated entry states |
| apr0_out | output | APR_WORDS*32 | Updated group-0 active-priority words |
| apr1_out | output | APR_WORDS*32 | Updated group-1 active-priority words |
| eoi_count | output | 5 | Count of unmatched end-of-interrupt writes |

## Verification
The priority drop is tested with several layouts of the active-priority words:
- A single bit in one group.
- Equal trailing-zero counts in both groups, which must pick group 0.
- Unequal counts, which must pick the lower bit in either group.
- A bit in the second word that is visible when `prebits` is 6 and hidden when it is 5.

The list-entry side is tested with these patterns:
- An entry that is both pending and active.
- Duplicate IDs, including a pending-only copy at a lower index.
- A group mismatch, and a priority mismatch.
- Group 1 with a binary point that is large enough to mask all priority bits, run once with the common-binary-point substitution and once without.
- Out-of-range IDs, and writes with no priority bit set.

Together these patterns separate each of the five outcome classes. A run of 33 unmatched writes checks that the counter wraps.

// File: rtl/veoi_pkg.sv
package veoi_pkg;

    localparam int ID_W     = 24;
    localparam int PRIO_W   = 8;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 5;
    localparam int BPR_W    = 3;

    // list entry state bit positions
    localparam int ST_PEND  = 0;
    localparam int ST_ACT   = 1;

    typedef enum logic [2:0] {
        EOI_IGNORE    = 3'd0,
        EOI_NOACT     = 3'd1,
        EOI_UNMATCHED = 3'd2,
        EOI_DEACT     = 3'd3,
        EOI_DROP_ONLY = 3'd4
    } eoi_kind_e;

    // trailing-zero count; an all-zero word yields WORD_W
    function automatic logic [5:0] tz_count(input logic [WORD_W-1:0] w);
        logic [5:0] r;
        r = 6'(WORD_W);
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (w[b]) r = 6'(b);
        end
        return r;
    endfunction

endpackage

// File: rtl/veoi_gprio_mask.sv
module veoi_gprio_mask
    import veoi_pkg::*;
(
    input  logic              grp,
    input  logic [BPR_W-1:0]  bpr_g0,
    input  logic [BPR_W-1:0]  bpr_g1,
    input  logic              common_bpr,
    output logic [PRIO_W-1:0] mask
);

    logic [BPR_W-1:0] sel_bpr;
    logic [4:0]       shamt;

    always_comb begin
        if (grp && !common_bpr) sel_bpr = bpr_g1;
        else                    sel_bpr = bpr_g0;
        shamt = 5'(sel_bpr) + 5'd1;
        mask  = {PRIO_W{1'b1}} << shamt;
    end

endmodule

// File: rtl/veoi_apr_drop.sv
module veoi_apr_drop
    import veoi_pkg::*;
#(
    parameter int APR_WORDS = 4
) (
    input  logic [APR_WORDS-1:0][WORD_W-1:0] apr0_in,
    input  logic [APR_WORDS-1:0][WORD_W-1:0] apr1_in,
    input  logic [2:0]                       prebits,
    input  logic [BPR_W-1:0]                 min_bpr,
    output logic [APR_WORDS-1:0][WORD_W-1:0] apr0_next,
    output logic [APR_WORDS-1:0][WORD_W-1:0] apr1_next,
    output logic                             found,
    output logic [PRIO_W-1:0]                drop_prio
);

    localparam int IDX_W = $clog2(APR_WORDS * WORD_W) + 1;

    logic [APR_WORDS-1:0] word_live;
    logic [APR_WORDS-1:0] word_busy;
    logic [3:0]           nwords;
    logic [5:0]           c0, c1;
    logic [IDX_W-1:0]     bit_idx;
    logic [31:0]          wide;

    always_comb begin
        if (prebits < 3'd5) nwords = 4'd1;
        else                nwords = 4'd1 << (prebits - 3'd5);
    end

    // per-word qualifiers
    for (genvar w = 0; w < APR_WORDS; w++) begin : g_word
        assign word_live[w] = (w < int'(nwords));
        assign word_busy[w] = word_live[w] && ((apr0_in[w] | apr1_in[w]) != '0);
    end

    always_comb begin
        apr0_next = apr0_in;
        apr1_next = apr1_in;
        found     = 1'b0;
        bit_idx   = '0;
        c0        = '0;
        c1        = '0;
        for (int w = 0; w < APR_WORDS; w++) begin
            if (!found && word_busy[w]) begin
                found = 1'b1;
                c0 = tz_count(apr0_in[w]);
                c1 = tz_count(apr1_in[w]);
                if (c0 <= c1) begin
                    apr0_next[w][c0[4:0]] = 1'b0;
                    bit_idx = IDX_W'(c0) + IDX_W'(w * WORD_W);
                end else begin
                    apr1_next[w][c1[4:0]] = 1'b0;
                    bit_idx = IDX_W'(c1) + IDX_W'(w * WORD_W);
                end
            end
        end
        wide = 32'(bit_idx) << (32'(min_bpr) + 32'd1);
        if (found) drop_prio = wide[PRIO_W-1:0];
        else       drop_prio = {PRIO_W{1'b1}};
    end

endmodule

// File: rtl/veoi_lr_match.sv
module veoi_lr_match
    import veoi_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic [ID_W-1:0]              id,
    input  logic [NUM_LR-1:0][ID_W-1:0]  lr_id,
    input  logic [NUM_LR-1:0][1:0]       lr_state,
    output logic                         hit,
    output logic [$clog2(NUM_LR+1)-1:0]  hit_idx
);

    localparam int IW = $clog2(NUM_LR + 1);

    logic [NUM_LR-1:0] cand;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_cand
        assign cand[i] = lr_state[i][ST_ACT] && (lr_id[i] == id);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/veoi_drop_unit.sv
module veoi_drop_unit
    import veoi_pkg::*;
#(
    parameter int NUM_LR    = 4,
    parameter int APR_WORDS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             eoi_wr,
    input  logic [31:0]                      eoi_data,
    input  logic                             eoi_grp,
    input  logic                             split_mode,
    input  logic [ID_W-1:0]                  num_irq,
    input  logic [2:0]                       prebits,
    input  logic [BPR_W-1:0]                 min_bpr,
    input  logic [BPR_W-1:0]                 bpr_g0,
    input  logic [BPR_W-1:0]                 bpr_g1,
    input  logic                             common_bpr,
    input  logic [NUM_LR-1:0][ID_W-1:0]      lr_id_in,
    input  logic [NUM_LR-1:0][PRIO_W-1:0]    lr_prio_in,
    input  logic [NUM_LR-1:0]                lr_grp_in,
    input  logic [NUM_LR-1:0][1:0]           lr_state_in,
    input  logic [APR_WORDS-1:0][WORD_W-1:0] apr0_in,
    input  logic [APR_WORDS-1:0][WORD_W-1:0] apr1_in,
    output logic [NUM_LR-1:0][1:0]           lr_state_out,
    output logic [APR_WORDS-1:0][WORD_W-1:0] apr0_out,
    output logic [APR_WORDS-1:0][WORD_W-1:0] apr1_out,
    output logic [CNT_W-1:0]                 eoi_count
);

    localparam int IW = $clog2(NUM_LR + 1);

    logic [ID_W-1:0]                  wr_id;
    logic                             id_ok;
    logic [APR_WORDS-1:0][WORD_W-1:0] apr0_drop, apr1_drop;
    logic                             drop_found;
    logic [PRIO_W-1:0]                drop_prio;
    logic                             lr_hit;
    logic [IW-1:0]                    lr_idx;
    logic [PRIO_W-1:0]                gmask;
    logic                             grp_eq, prio_eq;
    eoi_kind_e                        kind;

    logic [NUM_LR-1:0][1:0]           lr_nx;
    logic [APR_WORDS-1:0][WORD_W-1:0] apr0_nx, apr1_nx;
    logic [CNT_W-1:0]                 cnt_nx;

    assign wr_id = eoi_data[ID_W-1:0];
    assign id_ok = (wr_id < num_irq);

    veoi_apr_drop #(.APR_WORDS(APR_WORDS)) u_drop (
        .apr0_in   (apr0_in),
        .apr1_in   (apr1_in),
        .prebits   (prebits),
        .min_bpr   (min_bpr),
        .apr0_next (apr0_drop),
        .apr1_next (apr1_drop),
        .found     (drop_found),
        .drop_prio (drop_prio)
    );

    veoi_lr_match #(.NUM_LR(NUM_LR)) u_match (
        .id       (wr_id),
        .lr_id    (lr_id_in),
        .lr_state (lr_state_in),
        .hit      (lr_hit),
        .hit_idx  (lr_idx)
    );

    veoi_gprio_mask u_mask (
        .grp        (eoi_grp),
        .bpr_g0     (bpr_g0),
        .bpr_g1     (bpr_g1),
        .common_bpr (common_bpr),
        .mask       (gmask)
    );

    always_comb begin
        grp_eq  = (lr_grp_in[lr_idx] == eoi_grp);
        prio_eq = ((lr_prio_in[lr_idx] & gmask) == drop_prio);
    end

    // classify the write
    always_comb begin
        if (!id_ok)                                kind = EOI_IGNORE;
        else if (!drop_found)                      kind = EOI_NOACT;
        else if (!lr_hit)                          kind = EOI_UNMATCHED;
        else if (grp_eq && prio_eq && !split_mode) kind = EOI_DEACT;
        else                                       kind = EOI_DROP_ONLY;
    end

    // next values for each outcome
    always_comb begin
        lr_nx   = lr_state_in;
        apr0_nx = apr0_in;
        apr1_nx = apr1_in;
        cnt_nx  = eoi_count;
        unique case (kind)
            EOI_IGNORE, EOI_NOACT: begin
            end
            EOI_UNMATCHED: begin
                apr0_nx = apr0_drop;
                apr1_nx = apr1_drop;
                cnt_nx  = eoi_count + CNT_W'(1);
            end
            EOI_DEACT: begin
                apr0_nx = apr0_drop;
                apr1_nx = apr1_drop;
                lr_nx[lr_idx][ST_ACT] = 1'b0;
            end
            EOI_DROP_ONLY: begin
                apr0_nx = apr0_drop;
                apr1_nx = apr1_drop;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_state_out <= '0;
            apr0_out     <= '0;
            apr1_out     <= '0;
            eoi_count    <= '0;
        end else if (eoi_wr) begin
            lr_state_out <= lr_nx;
            apr0_out     <= apr0_nx;
            apr1_out     <= apr1_nx;
            eoi_count    <= cnt_nx;
        end
    end

    // ---------------- assertions ----------------
    logic [NUM_LR-1:0] pend_in, pend_out, act_in, act_out;
    for (genvar i = 0; i < NUM_LR; i++) begin : g_bits
        assign pend_in[i]  = lr_state_in[i][ST_PEND];
        assign pend_out[i] = lr_state_out[i][ST_PEND];
        assign act_in[i]   = lr_state_in[i][ST_ACT];
        assign act_out[i]  = lr_state_out[i][ST_ACT];
    end

    // R1
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && (eoi_data[ID_W-1:0] >= num_irq)) |=>
            (lr_state_out == $past(lr_state_in)) && (apr0_out == $past(apr0_in)) &&
            (apr1_out == $past(apr1_in)) && $stable(eoi_count));

    // R3
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> ($countones({apr0_out, apr1_out}) + 1 >= $countones($past({apr0_in, apr1_in}))));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> (eoi_count == $past(eoi_count)) || (eoi_count == $past(eoi_count) + CNT_W'(1)));

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> (pend_out == $past(pend_in)));

    // R10
    single_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> $onehot0($past(act_in) ^ act_out));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_wr |=> $stable(eoi_count) && $stable(lr_state_out) && $stable(apr0_out) && $stable(apr1_out));

endmodule

// File: tb/veoi_drop_unit_test.sv
module veoi_drop_unit_test;

    localparam int NLR = 4;
    localparam int AW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoi_wr = 1'b0;
    logic [31:0] eoi_data = '0;
    logic eoi_grp = 1'b0;
    logic split_mode = 1'b0;
    logic [23:0] num_irq = 24'd64;
    logic [2:0] prebits = 3'd5;
    logic [2:0] min_bpr = 3'd2;
    logic [2:0] bpr_g0 = 3'd2;
    logic [2:0] bpr_g1 = 3'd2;
    logic common_bpr = 1'b0;
    logic [NLR-1:0][23:0] lr_id_in = '0;
    logic [NLR-1:0][7:0]  lr_prio_in = '0;
    logic [NLR-1:0]       lr_grp_in = '0;
    logic [NLR-1:0][1:0]  lr_state_in = '0;
    logic [AW-1:0][31:0]  apr0_in = '0;
    logic [AW-1:0][31:0]  apr1_in = '0;
    logic [NLR-1:0][1:0]  lr_state_out;
    logic [AW-1:0][31:0]  apr0_out;
    logic [AW-1:0][31:0]  apr1_out;
    logic [4:0]           eoi_count;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    veoi_drop_unit #(.NUM_LR(NLR), .APR_WORDS(AW)) uut (
        .clk(clk), .rst_n(rst_n), .eoi_wr(eoi_wr), .eoi_data(eoi_data),
        .eoi_grp(eoi_grp), .split_mode(split_mode), .num_irq(num_irq),
        .prebits(prebits), .min_bpr(min_bpr), .bpr_g0(bpr_g0), .bpr_g1(bpr_g1),
        .common_bpr(common_bpr), .lr_id_in(lr_id_in), .lr_prio_in(lr_prio_in),
        .lr_grp_in(lr_grp_in), .lr_state_in(lr_state_in), .apr0_in(apr0_in),
        .apr1_in(apr1_in), .lr_state_out(lr_state_out), .apr0_out(apr0_out),
        .apr1_out(apr1_out), .eoi_count(eoi_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        lr_id_in = '0; lr_prio_in = '0; lr_grp_in = '0; lr_state_in = '0;
        apr0_in = '0; apr1_in = '0; prebits = 3'd5; min_bpr = 3'd2;
        bpr_g0 = 3'd2; bpr_g1 = 3'd2; common_bpr = 1'b0; split_mode = 1'b0;
        num_irq = 24'd64;
    endtask

    task automatic do_eoi(input logic grp, input logic [31:0] data);
        @(negedge clk);
        eoi_grp = grp; eoi_data = data; eoi_wr = 1'b1;
        @(negedge clk);
        eoi_wr = 1'b0;
    endtask

    // one active group-0 entry, id 40, prio 0x20, APR bit 4 of group 0
    task automatic base_setup();
        clear_in();
        lr_id_in[0] = 24'd40; lr_prio_in[0] = 8'h20; lr_state_in[0] = 2'b10;
        apr0_in[0] = 32'h10;
    endtask

    task automatic t_reset();
        chk("R11 reset lr", 32'(lr_state_out), 0);
        chk("R11 reset apr0", apr0_out[0], 0);
        chk("R5 reset count", 32'(eoi_count), 0);
    endtask

    task automatic t_deact();
        base_setup();
        do_eoi(1'b0, 32'd40);
        chk("R6 deact lr0", 32'(lr_state_out[0]), 32'b00);
        chk("R6 apr0 cleared", apr0_out[0], 0);
        chk("R6 count", 32'(eoi_count), exp_cnt);
        base_setup();
        lr_state_in[0] = 2'b11;
        do_eoi(1'b0, 32'hAB00_0028);
        chk("R6 R1 pending kept", 32'(lr_state_out[0]), 32'b01);
    endtask

    task automatic t_split();
        base_setup();
        split_mode = 1'b1;
        do_eoi(1'b0, 32'd40);
        chk("R7 lr stays active", 32'(lr_state_out[0]), 32'b10);
        chk("R7 apr dropped", apr0_out[0], 0);
        chk("R7 count", 32'(eoi_count), exp_cnt);
    endtask

    task automatic t_ignore();
        base_setup();
        do_eoi(1'b0, 32'd64);
        chk("R1 ignore lr", 32'(lr_state_out[0]), 32'b10);
        chk("R1 ignore apr", apr0_out[0], 32'h10);
        chk("R1 ignore count", 32'(eoi_count), exp_cnt);
        do_eoi(1'b0, 32'd1023);
        chk("R1 special id apr", apr0_out[0], 32'h10);
    endtask

    task automatic t_noact();
        base_setup();
        apr0_in = '0;
        do_eoi(1'b0, 32'd40);
        chk("R4 no active lr", 32'(lr_state_out[0]), 32'b10);
        chk("R4 no active count", 32'(eoi_count), exp_cnt);
    endtask

    task automatic t_unmatched_wrap();
        base_setup();
        do_eoi(1'b0, 32'd41);
        exp_cnt = (exp_cnt + 1) % 32;
        chk("R5 unmatched count", 32'(eoi_count), exp_cnt);
        chk("R5 apr dropped", apr0_out[0], 0);
        chk("R5 lr untouched", 32'(lr_state_out[0]), 32'b10);
        for (int k = 0; k < 32; k++) begin
            do_eoi(1'b0, 32'd41);
            exp_cnt = (exp_cnt + 1) % 32;
        end
        chk("R5 count wraps", 32'(eoi_count), exp_cnt);
    endtask

    task automatic t_tie();
        clear_in();
        apr0_in[0] = 32'h40; apr1_in[0] = 32'h40;
        do_eoi(1'b0, 32'd5); exp_cnt = (exp_cnt + 1) % 32;
        chk("R3 tie g0 cleared", apr0_out[0], 0);
        chk("R3 tie g1 kept", apr1_out[0], 32'h40);
        apr0_in[0] = 32'h80; apr1_in[0] = 32'h08;
        do_eoi(1'b0, 32'd5); exp_cnt = (exp_cnt + 1) % 32;
        chk("R3 lower g1 cleared", apr1_out[0], 0);
        chk("R3 g0 kept", apr0_out[0], 32'h80);
        apr0_in[0] = 32'h0; apr1_in[0] = 32'h0C;
        do_eoi(1'b0, 32'd5); exp_cnt = (exp_cnt + 1) % 32;
        chk("R3 only g1", apr1_out[0], 32'h08);
    endtask

    task automatic t_words();
        clear_in();
        prebits = 3'd6; min_bpr = 3'd1; bpr_g1 = 3'd1;
        apr0_in[1] = 32'h20; apr1_in[1] = 32'h01;
        lr_id_in[1] = 24'd7; lr_grp_in[1] = 1'b1; lr_prio_in[1] = 8'h80;
        lr_state_in[1] = 2'b10;
        do_eoi(1'b1, 32'd7);
        chk("R2 word1 g1 cleared", apr1_out[1], 0);
        chk("R2 word1 g0 kept", apr0_out[1], 32'h20);
        chk("R8 word1 prio deact", 32'(lr_state_out[1]), 32'b00);
        prebits = 3'd5; min_bpr = 3'd2;
        do_eoi(1'b1, 32'd7);
        chk("R2 word1 not scanned", apr1_out[1], 32'h01);
        chk("R2 lr kept", 32'(lr_state_out[1]), 32'b10);
        chk("R2 count", 32'(eoi_count), exp_cnt);
    endtask

    task automatic t_common_bpr();
        clear_in();
        bpr_g1 = 3'd7;
        lr_id_in[0] = 24'd12; lr_grp_in[0] = 1'b1; lr_prio_in[0] = 8'h28;
        lr_state_in[0] = 2'b10; apr1_in[0] = 32'h20;
        do_eoi(1'b1, 32'd12);
        chk("R9 full mask no deact", 32'(lr_state_out[0]), 32'b10);
        chk("R9 drop done", apr1_out[0], 0);
        chk("R9 count", 32'(eoi_count), exp_cnt);
        common_bpr = 1'b1;
        do_eoi(1'b1, 32'd12);
        chk("R8 common bpr deact", 32'(lr_state_out[0]), 32'b00);
    endtask

    task automatic t_mismatch();
        base_setup();
        lr_grp_in[0] = 1'b1;
        do_eoi(1'b0, 32'd40);
        chk("R9 group mismatch", 32'(lr_state_out[0]), 32'b10);
        chk("R9 group count", 32'(eoi_count), exp_cnt);
        base_setup();
        lr_prio_in[0] = 8'h30;
        do_eoi(1'b0, 32'd40);
        chk("R9 prio mismatch", 32'(lr_state_out[0]), 32'b10);
        chk("R9 prio apr", apr0_out[0], 0);
    endtask

    task automatic t_dup();
        clear_in();
        apr0_in[0] = 32'h10;
        for (int i = 0; i < NLR; i++) begin
            lr_id_in[i] = 24'd9; lr_prio_in[i] = 8'h20;
        end
        lr_state_in[0] = 2'b01; lr_state_in[1] = 2'b10;
        lr_state_in[2] = 2'b00; lr_state_in[3] = 2'b10;
        do_eoi(1'b0, 32'd9);
        chk("R10 pending-only skipped", 32'(lr_state_out[0]), 32'b01);
        chk("R10 lowest active cleared", 32'(lr_state_out[1]), 32'b00);
        chk("R10 higher kept", 32'(lr_state_out[3]), 32'b10);
    endtask

    task automatic t_hold();
        logic [7:0] snap;
        snap = {lr_state_out[3], lr_state_out[2], lr_state_out[1], lr_state_out[0]};
        lr_state_in = '1; apr0_in = '1;
        repeat (3) @(negedge clk);
        chk("R11 hold lr", 32'({lr_state_out[3], lr_state_out[2], lr_state_out[1], lr_state_out[0]}), 32'(snap));
        chk("R11 hold apr", apr0_out[0], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_deact();
        t_split();
        t_ignore();
        t_noact();
        t_unmatched_wrap();
        t_tie();
        t_words();
        t_common_bpr();
        t_mismatch();
        t_dup();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule